// File: doc/BRIEF.md
# SDIO Host Card Bring-Up Sequencer

This block runs the host side of card bring-up for I/O-only, memory-only and combo cards. It issues commands through an abstract command port. Each command carries a 6-bit index, a 32-bit argument and a flag that marks it as an application-specific command. The card answers with a response word, or the link layer reports that no response came back. The sequencer probes the I/O side with the I/O operating-conditions command (index 5) and then issues the interface-condition command (index 8). Next it probes memory with the application operating-conditions command (index 41). It assigns an address with index 3, preceded by index 2 when memory came up, or it parks an unusable card with index 15.

Both readiness polls run inside a one-second window that is derived from a clock-frequency parameter. Consecutive polls are spaced by a configurable number of idle cycles. When the flow ends, the block holds a card-kind code, a done flag, an unusable flag and the relative card address until the next start.

Top module: `sdio_init_seq`

## Requirements
- R1: Out of reset no command is issued, and done, unusable, card_type and rca are all 0.
- R2: A start pulse in the idle or finished state begins the flow with index 5 and argument 0. At most one command awaits an answer at a time. In an index-5 answer, bit 31 is ready, bits 30:28 give the function count, bit 27 is memory-present and bits 23:0 are the voltage window.
- R3: When the index-5 query times out, reports zero functions, or returns a window with no bit in common with VOLT_WIN, the I/O poll is skipped and the flow continues with index 8 and the memory probe.
- R4: The I/O poll repeats index 5 with argument {8'h0, VOLT_WIN} until bit 31 of the answer is 1. Two poll issues are at least RETRY_CYC cycles apart. A card still not ready once the window of CLK_HZ/1000*WINDOW_MS cycles has elapsed is declared unusable.
- R5: Index 8 is sent once per flow, after the I/O phase. The F8 flag is set exactly when index 8 gets an answer.
- R6: Memory probing is skipped when I/O came up and the memory-present bit was 0.
- R7: The memory probe sends index 41 with cmd_app=1 and argument 0. If bits 23:0 of the answer overlap VOLT_WIN, the block then polls index 41 with argument {1'b0, F8, 6'b0, VOLT_WIN} until bit 31 is 1. Bit 30 of the ready answer is the capacity bit. The same window and spacing as in R4 apply, and a window expiry makes the card unusable.
- R8: Index 2 (argument 0) is sent only when memory came up, and it is always followed by index 3. The rca output takes bits 31:16 of the index-3 answer.
- R9: An unusable card gets index 15 with argument 0, with no answer awaited. unusable is then set and card_type is set to 0.
- R10: card_type encoding: 1 I/O-only, 2 standard-capacity memory, 3 high-capacity memory, 4 standard-capacity combo, 5 high-capacity combo, 0 unusable. High capacity means the capacity bit is 1 and F8 is 1.
- R11: done stays high with its results unchanged until the next start. A start pulse during a running flow is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a bring-up flow |
| cmd_valid | output | 1 | One-cycle command strobe |
| cmd_idx | output | 6 | Command index |
| cmd_arg | output | 32 | Command argument |
| cmd_app | output | 1 | Command is application-specific |
| rsp_valid | input | 1 | Response strobe |
| rsp_timeout | input | 1 | No-response strobe |
| rsp_data | input | 32 | Response word |
| done | output | 1 | Flow finished |
| unusable | output | 1 | Card rejected |
| card_type | output | 3 | Card kind code |
| rca | output | 16 | Relative card address |

## Verification
The assertions assume that the link layer answers each command with exactly one rsp_valid or rsp_timeout strobe. They also assume that no strobe arrives for index 15 and that start is a single-cycle pulse. The bench card model answers every awaited command exactly once, a fixed number of cycles after cmd_valid, and never answers index 15. Stuck cards simply keep answering "not ready", so the window expiry is reached through the normal poll traffic.

// File: rtl/sdio_init_pkg.sv
package sdio_init_pkg;

  localparam logic [5:0] IDX_IO_OP    = 6'd5;
  localparam logic [5:0] IDX_IF_COND  = 6'd8;
  localparam logic [5:0] IDX_MEM_OP   = 6'd41;
  localparam logic [5:0] IDX_SEND_ID  = 6'd2;
  localparam logic [5:0] IDX_REL_ADDR = 6'd3;
  localparam logic [5:0] IDX_PARK     = 6'd15;

  typedef enum logic [3:0] {
    ST_IDLE, ST_IO_QUERY, ST_IO_POLL, ST_IF_COND, ST_MEM_QUERY,
    ST_MEM_POLL, ST_GAP, ST_SEND_ID, ST_REL_ADDR, ST_PARK, ST_FIN
  } seq_state_t;

  typedef enum logic [2:0] {
    CK_UNUSABLE = 3'd0,
    CK_IO_ONLY  = 3'd1,
    CK_MEM_SC   = 3'd2,
    CK_MEM_HC   = 3'd3,
    CK_COMBO_SC = 3'd4,
    CK_COMBO_HC = 3'd5
  } card_kind_t;

  // A reported voltage window is usable when it shares a bit with ours.
  function automatic logic window_fits(logic [23:0] card_win, logic [23:0] host_win);
    return |(card_win & host_win);
  endfunction

  function automatic card_kind_t classify(logic io, logic mem, logic f8, logic ccs);
    logic hc;
    hc = f8 & ccs;
    if (io && mem) return hc ? CK_COMBO_HC : CK_COMBO_SC;
    if (mem)       return hc ? CK_MEM_HC : CK_MEM_SC;
    if (io)        return CK_IO_ONLY;
    return CK_UNUSABLE;
  endfunction

  function automatic logic [31:0] mem_poll_arg(logic [23:0] host_win, logic hcs);
    return {1'b0, hcs, 6'b0, host_win};
  endfunction

endpackage

// File: rtl/sdio_cmd_port.sv
module sdio_cmd_port #(
  parameter int IDX_W = 6,
  parameter int ARG_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue,
  input  logic             expect_rsp,
  input  logic [IDX_W-1:0] idx_in,
  input  logic [ARG_W-1:0] arg_in,
  input  logic             app_in,
  input  logic             rsp_valid,
  input  logic             rsp_timeout,
  output logic             cmd_valid,
  output logic [IDX_W-1:0] cmd_idx,
  output logic [ARG_W-1:0] cmd_arg,
  output logic             cmd_app,
  output logic             pending,
  output logic             ev_ok,
  output logic             ev_to
);

  assign ev_ok = pending & rsp_valid;
  assign ev_to = pending & rsp_timeout & ~rsp_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_valid <= 1'b0;
      cmd_idx   <= '0;
      cmd_arg   <= '0;
      cmd_app   <= 1'b0;
      pending   <= 1'b0;
    end else begin
      cmd_valid <= issue;
      if (issue) begin
        cmd_idx <= idx_in;
        cmd_arg <= arg_in;
        cmd_app <= app_in;
      end
      if (issue) pending <= expect_rsp;
      else if (ev_ok || ev_to) pending <= 1'b0;
    end
  end

  // R2: a new command never overlaps one still awaiting its answer
  a_r2_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    issue |-> !pending);

endmodule

// File: rtl/sdio_poll_timer.sv
module sdio_poll_timer #(
  parameter int unsigned LIMIT     = 1000,
  parameter int unsigned RETRY_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic win_start,
  input  logic gap_start,
  output logic win_expired,
  output logic gap_done
);

  localparam int WIN_W = $clog2(LIMIT + 2);
  localparam int GAP_W = $clog2(RETRY_CYC + 2);
  localparam logic [WIN_W-1:0] WIN_MAX = WIN_W'(LIMIT);
  localparam logic [GAP_W-1:0] GAP_LD  = GAP_W'(RETRY_CYC);

  logic [WIN_W-1:0] win_cnt;
  logic [GAP_W-1:0] gap_cnt;

  assign win_expired = (win_cnt >= WIN_MAX);
  assign gap_done    = (gap_cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_cnt <= '0;
      gap_cnt <= '0;
    end else begin
      if (win_start)        win_cnt <= '0;
      else if (!win_expired) win_cnt <= win_cnt + 1'b1;
      if (gap_start)        gap_cnt <= GAP_LD;
      else if (!gap_done)   gap_cnt <= gap_cnt - 1'b1;
    end
  end

  // R4: once the window has run out it stays out until a new poll phase
  a_r4_window_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (win_expired && !win_start) |=> win_expired);

endmodule

// File: rtl/sdio_init_seq.sv
module sdio_init_seq
  import sdio_init_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 50_000_000,
  parameter int unsigned WINDOW_MS   = 1000,
  parameter int unsigned RETRY_CYC   = 64,
  parameter logic [23:0] VOLT_WIN    = 24'h30_0000,
  parameter logic [31:0] IF_COND_ARG = 32'h0000_01AA
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  output logic        cmd_valid,
  output logic [5:0]  cmd_idx,
  output logic [31:0] cmd_arg,
  output logic        cmd_app,
  input  logic        rsp_valid,
  input  logic        rsp_timeout,
  input  logic [31:0] rsp_data,
  output logic        done,
  output logic        unusable,
  output logic [2:0]  card_type,
  output logic [15:0] rca
);

  localparam int unsigned LIMIT = (CLK_HZ / 1000) * WINDOW_MS;

  seq_state_t state, gap_ret;
  card_kind_t kind_q;
  logic       wait_q;
  logic       io_f, mem_f, f8_f, ccs_f, mp_f;

  // command issue request
  logic        issue, expect_rsp, app_req;
  logic [5:0]  idx_req;
  logic [31:0] arg_req;
  logic        pending, ev_ok, ev_to, ev_any;
  logic        win_start, gap_start, win_expired, gap_done;

  // response field decode
  logic        r_ready, r_mp, r_ccs;
  logic [2:0]  r_nf;
  logic [23:0] r_win;
  logic        io_accept, mem_accept, poll_state, poll_ready;

  assign r_ready = rsp_data[31];
  assign r_nf    = rsp_data[30:28];
  assign r_mp    = rsp_data[27];
  assign r_ccs   = rsp_data[30];
  assign r_win   = rsp_data[23:0];
  assign ev_any  = ev_ok | ev_to;

  assign io_accept  = ev_ok && (r_nf != 3'd0) && window_fits(r_win, VOLT_WIN);
  assign mem_accept = ev_ok && window_fits(r_win, VOLT_WIN);
  assign poll_state = (state == ST_IO_POLL) || (state == ST_MEM_POLL);
  assign poll_ready = ev_ok && r_ready;

  assign win_start = wait_q && (((state == ST_IO_QUERY) && io_accept) ||
                                ((state == ST_MEM_QUERY) && mem_accept));
  assign gap_start = wait_q && poll_state && ev_any && !poll_ready && !win_expired;

  always_comb begin
    idx_req    = '0;
    arg_req    = '0;
    app_req    = 1'b0;
    expect_rsp = 1'b1;
    issue      = 1'b0;
    case (state)
      ST_IO_QUERY:  begin idx_req = IDX_IO_OP;    issue = !wait_q; end
      ST_IO_POLL:   begin idx_req = IDX_IO_OP;    arg_req = {8'h00, VOLT_WIN}; issue = !wait_q; end
      ST_IF_COND:   begin idx_req = IDX_IF_COND;  arg_req = IF_COND_ARG; issue = !wait_q; end
      ST_MEM_QUERY: begin idx_req = IDX_MEM_OP;   app_req = 1'b1; issue = !wait_q; end
      ST_MEM_POLL:  begin
        idx_req = IDX_MEM_OP;
        app_req = 1'b1;
        arg_req = mem_poll_arg(VOLT_WIN, f8_f);
        issue   = !wait_q;
      end
      ST_SEND_ID:   begin idx_req = IDX_SEND_ID;  issue = !wait_q; end
      ST_REL_ADDR:  begin idx_req = IDX_REL_ADDR; issue = !wait_q; end
      ST_PARK:      begin idx_req = IDX_PARK;     expect_rsp = 1'b0; issue = 1'b1; end
      default: ;
    endcase
  end

  sdio_cmd_port #(.IDX_W(6), .ARG_W(32)) u_port (
    .clk        (clk),
    .rst_n      (rst_n),
    .issue      (issue),
    .expect_rsp (expect_rsp),
    .idx_in     (idx_req),
    .arg_in     (arg_req),
    .app_in     (app_req),
    .rsp_valid  (rsp_valid),
    .rsp_timeout(rsp_timeout),
    .cmd_valid  (cmd_valid),
    .cmd_idx    (cmd_idx),
    .cmd_arg    (cmd_arg),
    .cmd_app    (cmd_app),
    .pending    (pending),
    .ev_ok      (ev_ok),
    .ev_to      (ev_to)
  );

  sdio_poll_timer #(.LIMIT(LIMIT), .RETRY_CYC(RETRY_CYC)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .win_start  (win_start),
    .gap_start  (gap_start),
    .win_expired(win_expired),
    .gap_done   (gap_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      gap_ret  <= ST_IDLE;
      wait_q   <= 1'b0;
      io_f     <= 1'b0;
      mem_f    <= 1'b0;
      f8_f     <= 1'b0;
      ccs_f    <= 1'b0;
      mp_f     <= 1'b0;
      done     <= 1'b0;
      unusable <= 1'b0;
      kind_q   <= CK_UNUSABLE;
      rca      <= '0;
    end else begin
      case (state)
        ST_IDLE, ST_FIN: begin
          if (start) begin
            state    <= ST_IO_QUERY;
            wait_q   <= 1'b0;
            io_f     <= 1'b0;
            mem_f    <= 1'b0;
            f8_f     <= 1'b0;
            ccs_f    <= 1'b0;
            mp_f     <= 1'b0;
            done     <= 1'b0;
            unusable <= 1'b0;
            kind_q   <= CK_UNUSABLE;
            rca      <= '0;
          end
        end
        ST_GAP: if (gap_done) state <= gap_ret;
        ST_PARK: begin
          state    <= ST_FIN;
          done     <= 1'b1;
          unusable <= 1'b1;
          kind_q   <= CK_UNUSABLE;
        end
        default: begin
          if (!wait_q) begin
            wait_q <= 1'b1;
          end else if (ev_any) begin
            wait_q <= 1'b0;
            case (state)
              ST_IO_QUERY: begin
                if (io_accept) begin
                  mp_f  <= r_mp;
                  state <= ST_IO_POLL;
                end else begin
                  mp_f  <= 1'b1;
                  state <= ST_IF_COND;
                end
              end
              ST_IO_POLL: begin
                if (poll_ready) begin
                  io_f  <= 1'b1;
                  state <= ST_IF_COND;
                end else if (win_expired) begin
                  state <= ST_PARK;
                end else begin
                  gap_ret <= ST_IO_POLL;
                  state   <= ST_GAP;
                end
              end
              ST_IF_COND: begin
                f8_f  <= ev_ok;
                state <= (io_f && !mp_f) ? ST_REL_ADDR : ST_MEM_QUERY;
              end
              ST_MEM_QUERY: begin
                if (mem_accept) state <= ST_MEM_POLL;
                else            state <= io_f ? ST_REL_ADDR : ST_PARK;
              end
              ST_MEM_POLL: begin
                if (poll_ready) begin
                  mem_f <= 1'b1;
                  ccs_f <= r_ccs;
                  state <= ST_SEND_ID;
                end else if (win_expired) begin
                  state <= ST_PARK;
                end else begin
                  gap_ret <= ST_MEM_POLL;
                  state   <= ST_GAP;
                end
              end
              ST_SEND_ID: state <= ev_ok ? ST_REL_ADDR : ST_PARK;
              ST_REL_ADDR: begin
                if (ev_ok) begin
                  rca    <= rsp_data[31:16];
                  kind_q <= classify(io_f, mem_f, f8_f, ccs_f);
                  done   <= 1'b1;
                  state  <= ST_FIN;
                end else begin
                  state  <= ST_PARK;
                end
              end
              default: state <= ST_IDLE;
            endcase
          end
        end
      endcase
    end
  end

  assign card_type = kind_q;

  // R8: identification request only after memory came up
  a_r8_id_needs_mem: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_idx == IDX_SEND_ID) |-> mem_f);

  // R7: capacity-support bit only requested after an interface-condition answer
  a_r7_hcs_needs_f8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_idx == IDX_MEM_OP && cmd_arg[30]) |-> f8_f);

  // R9: park command carries a zero argument
  a_r9_park_zero_arg: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_idx == IDX_PARK) |-> (cmd_arg == 32'h0));

  // R10: a usable finish always carries a non-zero kind, an unusable one zero
  a_r10_kind_matches: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (unusable == (card_type == 3'd0)));

  // R11: results hold until the next start
  a_r11_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(card_type) && $stable(rca)));

endmodule

// File: tb/sdio_init_seq_test.sv
module sdio_init_seq_test;

  localparam int CLK_PERIOD = 10;
  localparam int TB_CLK_HZ  = 1000;
  localparam int TB_WIN_MS  = 1000;
  localparam int TB_RETRY   = 12;
  localparam int STUCK      = 100000;
  localparam logic [23:0] TB_WIN = 24'h30_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        cmd_valid, cmd_app;
  logic [5:0]  cmd_idx;
  logic [31:0] cmd_arg;
  logic        rsp_valid = 1'b0;
  logic        rsp_timeout = 1'b0;
  logic [31:0] rsp_data = '0;
  logic        done, unusable;
  logic [2:0]  card_type;
  logic [15:0] rca;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdio_init_seq #(
    .CLK_HZ(TB_CLK_HZ), .WINDOW_MS(TB_WIN_MS), .RETRY_CYC(TB_RETRY), .VOLT_WIN(TB_WIN)
  ) uut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cmd_valid(cmd_valid), .cmd_idx(cmd_idx), .cmd_arg(cmd_arg), .cmd_app(cmd_app),
    .rsp_valid(rsp_valid), .rsp_timeout(rsp_timeout), .rsp_data(rsp_data),
    .done(done), .unusable(unusable), .card_type(card_type), .rca(rca)
  );

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  // card model configuration
  int  c_io_mode;   // 0 silent, 1 zero functions, 2 bad window, 3 good
  int  c_io_after;
  bit  c_mp;
  bit  c_f8;
  int  c_mem_mode;  // 0 silent, 1 bad window, 2 good
  int  c_mem_after;
  bit  c_ccs;
  logic [15:0] c_rca;

  // observations
  int  n5q, n5p, n41, io_polls, mem_polls, last_poll;
  bit  saw2, saw3, saw15, hcs_seen, gap_bad, app_bad;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // card model: answers two cycles after each command
  initial begin
    int          cnt;
    logic [31:0] pend_data;
    bit          pend_to;
    cnt = 0; pend_data = '0; pend_to = 0;
    forever begin
      @(negedge clk);
      cyc++;
      rsp_valid = 1'b0;
      rsp_timeout = 1'b0;
      if (cnt == 1) begin
        if (pend_to) rsp_timeout = 1'b1;
        else begin rsp_valid = 1'b1; rsp_data = pend_data; end
      end
      if (cnt > 0) cnt--;
      if (cmd_valid) begin
        pend_to = 0; pend_data = '0; cnt = 2;
        case (cmd_idx)
          6'd5: begin
            if (cmd_app) app_bad = 1;
            if (c_io_mode == 0) pend_to = 1;
            else if (cmd_arg == 0) begin
              n5q++;
              pend_data = {1'b0, (c_io_mode == 1) ? 3'd0 : 3'd3, c_mp, 3'b0,
                           (c_io_mode == 2) ? 24'h00_0080 : 24'hFF_8000};
            end else begin
              if (n5p > 0 && cyc - last_poll < TB_RETRY) gap_bad = 1;
              last_poll = cyc;
              n5p++;
              pend_data = {(io_polls >= c_io_after), 3'd3, c_mp, 3'b0, 24'hFF_8000};
              io_polls++;
            end
          end
          6'd8: begin
            if (c_f8) pend_data = cmd_arg; else pend_to = 1;
          end
          6'd41: begin
            if (!cmd_app) app_bad = 1;
            n41++;
            if (c_mem_mode == 0) pend_to = 1;
            else if (cmd_arg == 0) begin
              pend_data = {8'h00, (c_mem_mode == 1) ? 24'h00_0080 : 24'hFF_8000};
            end else begin
              if (mem_polls > 0 && cyc - last_poll < TB_RETRY) gap_bad = 1;
              last_poll = cyc;
              hcs_seen = cmd_arg[30];
              pend_data = {(mem_polls >= c_mem_after),
                           (mem_polls >= c_mem_after) ? c_ccs : 1'b0, 6'b0, 24'hFF_8000};
              mem_polls++;
            end
          end
          6'd2: begin
            saw2 = 1;
            if (c_mem_mode != 2) pend_to = 1;
          end
          6'd3: begin
            saw3 = 1;
            pend_data = {c_rca, 16'h0000};
          end
          6'd15: begin
            saw15 = 1;
            cnt = 0;
          end
          default: pend_to = 1;
        endcase
      end
    end
  end

  function automatic int exp_kind(bit io, bit mem, bit f8, bit ccs);
    int base;
    if (!io && !mem) return 0;
    if (!mem) return 1;
    base = io ? 4 : 2;
    return (f8 && ccs) ? base + 1 : base;
  endfunction

  task automatic run_trial(input int io_mode, input int io_after, input bit mp, input bit f8,
                           input int mem_mode, input int mem_after, input bit ccs,
                           input logic [15:0] the_rca, input bit restart_mid);
    bit io_ok, io_stuck, mem_try, mem_ok, mem_stuck, unus;
    int ek, wd;
    c_io_mode = io_mode; c_io_after = io_after; c_mp = mp; c_f8 = f8;
    c_mem_mode = mem_mode; c_mem_after = mem_after; c_ccs = ccs; c_rca = the_rca;
    n5q = 0; n5p = 0; n41 = 0; io_polls = 0; mem_polls = 0; last_poll = 0;
    saw2 = 0; saw3 = 0; saw15 = 0; hcs_seen = 0; gap_bad = 0; app_bad = 0;

    io_ok     = (io_mode == 3);
    io_stuck  = io_ok && io_after >= STUCK;
    mem_try   = !io_stuck && (!io_ok || mp);
    mem_ok    = mem_try && mem_mode == 2;
    mem_stuck = mem_ok && mem_after >= STUCK;
    unus      = io_stuck || mem_stuck || (!io_ok && !mem_ok);
    ek        = unus ? 0 : exp_kind(io_ok, mem_ok, f8, ccs);

    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (restart_mid) begin
      repeat (8) @(negedge clk);
      start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    wd = 0;
    while (!done && wd < 5000) begin @(negedge clk); wd++; end
    chk(done == 1'b1, "R11 watchdog/done", done, 1);
    if (!done) return;

    chk(card_type == 3'(ek), "R10 card kind", card_type, ek);
    chk(unusable == unus, "R9 unusable flag", unusable, unus);
    chk(saw15 == unus, "R9 park command", saw15, unus);
    chk(n5q == (io_mode == 0 ? 0 : 1), "R2 single I/O query", n5q, io_mode == 0 ? 0 : 1);
    if (!io_ok) chk(n5p == 0, "R3 I/O poll skipped", n5p, 0);
    else if (!io_stuck) chk(n5p == io_after + 1, "R4 I/O poll count", n5p, io_after + 1);
    else chk(n5p > 10, "R4 I/O window expiry", n5p, 11);
    chk(!gap_bad, "R4 poll spacing", gap_bad, 0);
    chk(!app_bad, "R7 app flag", app_bad, 0);
    if (!mem_try) chk(n41 == 0, "R6 memory skipped", n41, 0);
    else if (mem_ok && !mem_stuck) begin
      chk(n41 == mem_after + 2, "R7 memory poll count", n41, mem_after + 2);
      chk(hcs_seen == f8, "R5 capacity request follows F8", hcs_seen, f8);
    end
    chk(saw2 == (mem_ok && !mem_stuck), "R8 identification only with memory", saw2, mem_ok && !mem_stuck);
    if (!unus) begin
      chk(saw3, "R8 address request", saw3, 1);
      chk(rca == the_rca, "R8 rca capture", rca, the_rca);
    end
    repeat (5) @(negedge clk);
    chk(done && card_type == 3'(ek), "R11 results held", card_type, ek);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(!cmd_valid && !done && !unusable && card_type == 0 && rca == 0, "R1 reset state",
        {cmd_valid, done, unusable, card_type}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!cmd_valid && !done, "R1 idle after reset", {cmd_valid, done}, 0);

    // directed corners
    run_trial(3, 2, 0, 1, 2, 1, 1, 16'h1111, 0);     // I/O only (MP=0)
    run_trial(0, 0, 0, 1, 2, 3, 1, 16'h2222, 0);     // R3 silent I/O, HC memory
    run_trial(0, 0, 0, 0, 2, 0, 1, 16'h3333, 0);     // R10 CCS ignored without F8
    run_trial(3, 1, 1, 1, 2, 2, 1, 16'h4444, 1);     // HC combo, restart ignored (R11)
    run_trial(3, 0, 1, 0, 2, 0, 0, 16'h5555, 0);     // SC combo
    run_trial(1, 0, 1, 1, 0, 0, 0, 16'h6666, 0);     // nothing works
    run_trial(3, STUCK, 1, 1, 2, 0, 0, 16'h7777, 0); // I/O never ready
    run_trial(2, 0, 0, 1, 2, STUCK, 0, 16'h8888, 0); // memory never ready
    run_trial(3, 0, 1, 1, 1, 0, 0, 16'h9999, 0);     // memory bad window, I/O only

    for (int t = 0; t < 24; t++) begin
      int iom, mm;
      iom = $urandom_range(0, 3);
      mm  = $urandom_range(0, 2);
      run_trial(iom, ($urandom_range(0, 15) == 0) ? STUCK : $urandom_range(0, 5),
                1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), mm,
                ($urandom_range(0, 15) == 0) ? STUCK : $urandom_range(0, 5),
                1'($urandom_range(0, 1)), 16'($urandom_range(1, 65535)),
                1'($urandom_range(0, 1)));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    errors++;
    checks++;
    $display("FAIL R11 global watchdog actual=%0d expected=%0d", cyc, 190000);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule